// File: doc/BRIEF.md
# Two-Wire Slave for a 10-bit Output-Code Register

This block is the serial-bus front end of a converter channel. It owns one 10-bit output-code register and exposes it to a two-wire bus master. Clock and data lines are sampled by a fast system clock. Data is driven back through an open-drain enable: a 1 pulls the line low, and a 0 releases it.

A write sends the device address with the direction bit cleared, then a high byte and then a low byte. Only the two low bits of the high byte are code bits. The register takes the new value only when the low byte is complete. A read returns the high byte, which carries a programming-status field in its top nibble, and then the low byte. The block also handles two special first bytes:
- A high-speed master code, which raises a flag the analog side uses to select its input filters.
- A general-call address, which can be followed by a reset command.

Reset, whether from the reset pin or from the bus, loads the stored programmed value into the register. If the store has never been programmed, it loads mid-scale instead.

Top module: `dacif_slave`

## Requirements
- R1: While `rst_n` is low and after it is released, `dac_code_o` equals `otp_value_i` when `otp_count_i` is nonzero, and equals 10'h200 when it is zero. `sda_oe_o` and `hs_mode_o` are 0 after reset.
- R2: A write sends address byte {DEV_ADDR, 0}, a high byte H and a low byte L. The slave pulls SDA low in the ninth clock after each of the three bytes. After the stop, `dac_code_o` equals {H[1:0], L}.
- R3: If a STOP or a START arrives before the ninth clock of the low byte begins, the register keeps its old value. This holds even when the START comes in the high phase of the low byte's eighth bit.
- R4: If bits 7:5 of the high byte are 3'b010 or 3'b001, the slave still acknowledges both data bytes, but the register is not changed.
- R5: A read sends address byte {DEV_ADDR, 1} and receives an acknowledge. The slave then returns a first byte of {status[3:0], 2'b00, code[9:8]} and a second byte of code[7:0], most significant bit first.
- R6: The status nibble is a thermometer code of `otp_count_i`: 0→0000, 1→0001, 2→0011, 3→0111, and 4 or more→1111.
- R7: When the master leaves SDA high in the acknowledge clock after a read byte, the slave releases SDA and sends nothing more until the next START. It also releases SDA after the second read byte.
- R8: A first byte of the form 8'b00001xxx, for any xxx, is not acknowledged and sets `hs_mode_o`. The flag stays set across repeated STARTs and clears at the next STOP.
- R9: Address byte 8'h00 is always acknowledged. A following data byte of 8'h06 is acknowledged and reloads the register as in R1. Any other data byte is not acknowledged and leaves the register unchanged.
- R10: An address byte for another device (any byte not covered by R2, R5, R8 or R9) is not acknowledged and leaves the register unchanged.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| otp_count_i | input | 3 | Number of times the stored value was programmed |
| otp_value_i | input | 10 | Programmed code used at reset |
| dac_code_o | output | 10 | Current output-code register |
| hs_mode_o | output | 1 | High-speed filter select |

## Verification
Two events can meet in the same SCL period: the commit of a write and an early termination. The bench provokes this by raising SCL for the eighth bit of the low byte and then dropping SDA while SCL is still high. This sends a START before the commit edge, so the register must keep its old value. A second overlap occurs when a general-call reset and a read's status field both depend on the programming-count input. The bench therefore changes that input between transactions and checks that both the reloaded value and the status nibble follow its current level.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } st_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_MSB,
        K_LSB,
        K_GC,
        K_RD,
        K_END
    } kind_e;

    localparam logic [7:0] GC_ADDR_BYTE  = 8'h00;
    localparam logic [7:0] GC_RESET_BYTE = 8'h06;
    localparam logic [4:0] HS_PREFIX     = 5'b00001;
    localparam int         STAT_W        = 4;

    typedef struct packed {
        st_e        st;
        kind_e      kind;
        logic [3:0] cnt;
        logic [7:0] sr;
        logic [7:0] msb;
        logic       oe;
        logic       hs;
        logic       rsv;
        logic       second;
        logic       mack;
    } fsm_t;

endpackage

// File: rtl/dacif_line_sync.sv
module dacif_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // [0] first stage, [1] synchronized, [2] previous synchronized value
    logic [2:0] scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[1:0], scl_i};
        sda_d = {sda_q[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_o      = scl_q[1];
    assign sda_o      = sda_q[1];
    assign scl_rise_o = scl_q[1] & ~scl_q[2];
    assign scl_fall_o = ~scl_q[1] & scl_q[2];
    assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/dacif_otp_status.sv
module dacif_otp_status #(
    parameter int CNT_W  = 3,
    parameter int STAT_W = 4
) (
    input  logic [CNT_W-1:0]  count_i,
    output logic [STAT_W-1:0] therm_o
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_therm
        assign therm_o[i] = (int'(count_i) > i);
    end

    always_comb begin
        if (!$isunknown(count_i)) begin
            p_therm_weight_r6: assert ($countones(therm_o) ==
                ((int'(count_i) > STAT_W) ? STAT_W : int'(count_i)));
        end
    end

endmodule

// File: rtl/dacif_code_reg.sv
module dacif_code_reg #(
    parameter int CODE_W = 10,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_val_i,
    input  logic [CNT_W-1:0]  otp_count_i,
    input  logic [CODE_W-1:0] otp_value_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] MID_SCALE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] code_d, code_q, init_val;

    always_comb begin
        init_val = (otp_count_i == '0) ? MID_SCALE : otp_value_i;
        code_d   = code_q;
        if (!rst_n || reload_i) begin
            code_d = init_val;
        end else if (load_i) begin
            code_d = load_val_i;
        end
    end

    // synchronous reset: the reset value is an input, not a constant
    always_ff @(posedge clk) begin
        code_q <= code_d;
    end

    assign code_o = code_q;

    p_reload_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (code_q == $past(init_val)));

endmodule

// File: rtl/dacif_slave.sv
module dacif_slave
    import dacif_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         CODE_W   = 10,
    parameter int         CNT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [CNT_W-1:0]  otp_count_i,
    input  logic [CODE_W-1:0] otp_value_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              hs_mode_o
);
    localparam int HI_W  = CODE_W - 8;
    localparam int PAD_W = 8 - STAT_W - HI_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic load, reload;
    logic [CODE_W-1:0] load_val, code;
    logic [STAT_W-1:0] therm;
    logic [7:0] rd_msb, rd_lsb;
    fsm_t q, d;

    dacif_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    dacif_otp_status #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_stat (
        .count_i (otp_count_i),
        .therm_o (therm)
    );

    dacif_code_reg #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_i    (reload),
        .load_i      (load),
        .load_val_i  (load_val),
        .otp_count_i (otp_count_i),
        .otp_value_i (otp_value_i),
        .code_o      (code)
    );

    assign rd_msb   = {therm, {PAD_W{1'b0}}, code[CODE_W-1:8]};
    assign rd_lsb   = code[7:0];
    assign load_val = {q.msb[HI_W-1:0], q.sr};

    always_comb begin
        d      = q;
        load   = 1'b0;
        reload = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
            d.hs = 1'b0;
        end else if (start_det) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = '0;
            d.sr   = '0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_SKIP;
                        case (q.kind)
                            K_ADDR: begin
                                if (q.sr[7:3] == HS_PREFIX) begin
                                    d.hs = 1'b1;
                                end else if (q.sr == GC_ADDR_BYTE) begin
                                    d.st = ST_ACK; d.oe = 1'b1; d.kind = K_GC;
                                end else if (q.sr[7:1] == DEV_ADDR) begin
                                    d.st = ST_ACK; d.oe = 1'b1;
                                    d.kind = q.sr[0] ? K_RD : K_MSB;
                                end
                            end
                            K_MSB: begin
                                d.msb  = q.sr;
                                d.rsv  = (q.sr[7:5] == 3'b010) || (q.sr[7:5] == 3'b001);
                                d.st   = ST_ACK; d.oe = 1'b1; d.kind = K_LSB;
                            end
                            K_LSB: begin
                                load   = !q.rsv;
                                d.st   = ST_ACK; d.oe = 1'b1; d.kind = K_END;
                            end
                            K_GC: begin
                                if (q.sr == GC_RESET_BYTE) begin
                                    reload = 1'b1;
                                    d.st   = ST_ACK; d.oe = 1'b1; d.kind = K_END;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        case (q.kind)
                            K_RD: begin
                                d.st     = ST_TX;
                                d.sr     = rd_msb;
                                d.oe     = ~rd_msb[7];
                                d.second = 1'b0;
                            end
                            K_END:   d.st = ST_SKIP;
                            default: begin d.st = ST_RX; d.sr = '0; end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe  = 1'b0;
                            d.st  = ST_MACK;
                            d.cnt = '0;
                        end else begin
                            d.sr  = {q.sr[6:0], 1'b0};
                            d.oe  = ~q.sr[6];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack && !q.second) begin
                            d.st     = ST_TX;
                            d.sr     = rd_lsb;
                            d.oe     = ~rd_lsb[7];
                            d.second = 1'b1;
                        end else begin
                            d.st = ST_SKIP;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o   = q.oe;
    assign hs_mode_o  = q.hs;
    assign dac_code_o = code;

    // R11: the open-drain enable only moves while the clock line is low
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl_s);

    // R8: the flag is dropped by a STOP
    p_hs_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.hs);

    // R8: the master code is never acknowledged
    p_hs_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.hs) |-> !q.oe);

    // R3: the register moves only at the end of a low byte or a bus reset
    p_code_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |->
        ($past(q.st) == ST_RX && ($past(q.kind) == K_LSB || $past(q.kind) == K_GC)));

endmodule

// File: tb/tb_dacif_slave.sv
module tb_dacif_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam logic [6:0] ADDR = 7'h4C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [2:0] otp_cnt = 3'd0;
    logic [9:0] otp_val = 10'h000;
    logic sda_oe, hs;
    logic [9:0] code;
    logic bus_sda;

    int n_checks = 0;
    int n_fail = 0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    logic [9:0] exp_code;

    assign bus_sda = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacif_slave #(.DEV_ADDR(ADDR)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (bus_sda),
        .sda_oe_o    (sda_oe),
        .otp_count_i (otp_cnt),
        .otp_value_i (otp_val),
        .dac_code_o  (code),
        .hs_mode_o   (hs)
    );

    // R11 monitor
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) oe_viol++;
        prev_oe  = sda_oe;
        prev_scl = m_scl;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] therm_of(input logic [2:0] c);
        case (c)
            3'd0: return 4'b0000;
            3'd1: return 4'b0001;
            3'd2: return 4'b0011;
            3'd3: return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [9:0] rst_val();
        return (otp_cnt == 3'd0) ? 10'h200 : otp_val;
    endfunction

    function automatic logic is_rsv(input logic [7:0] h);
        return (h[7:5] == 3'b010) || (h[7:5] == 3'b001);
    endfunction

    task automatic wbit(input logic b);
        m_sda = b; wt(Q); m_scl = 1'b1; wt(2*Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); b = bus_sda; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~mack);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wt(5); rst_n = 1'b1; wt(5);
        exp_code = rst_val();
    endtask

    task automatic do_write(input logic [7:0] h, input logic [7:0] l);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R2 addr ack", int'(a), 1);
        send_byte(h, a); chk(is_rsv(h) ? "R4 msb ack" : "R2 msb ack", int'(a), 1);
        send_byte(l, a); chk(is_rsv(h) ? "R4 lsb ack" : "R2 lsb ack", int'(a), 1);
        bus_stop();
        if (!is_rsv(h)) exp_code = {h[1:0], l};
        wt(4);
        chk(is_rsv(h) ? "R4 register" : "R2 register", int'(code), int'(exp_code));
    endtask

    task automatic do_read();
        logic a;
        logic [7:0] m, l;
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk("R5 addr ack", int'(a), 1);
        recv_byte(m, 1'b1);
        recv_byte(l, 1'b0);
        wt(2);
        chk("R7 released after second byte", int'(sda_oe), 0);
        bus_stop();
        chk("R5 msb code bits", int'(m[3:0]), int'({2'b00, exp_code[9:8]}));
        chk("R6 status nibble", int'(m[7:4]), int'(therm_of(otp_cnt)));
        chk("R5 lsb", int'(l), int'(exp_code[7:0]));
    endtask

    task automatic do_gc(input logic [7:0] data);
        logic a;
        bus_start();
        send_byte(8'h00, a); chk("R9 gc addr ack", int'(a), 1);
        send_byte(data, a); chk("R9 gc data ack", int'(a), (data == 8'h06) ? 1 : 0);
        bus_stop();
        if (data == 8'h06) exp_code = rst_val();
        wt(4);
        chk("R9 register after gc", int'(code), int'(exp_code));
    endtask

    task automatic do_abort(input int kind, input logic [7:0] h, input logic [7:0] l);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R3 addr ack", int'(a), 1);
        send_byte(h, a); chk("R3 msb ack", int'(a), 1);
        if (kind == 0) begin
            bus_stop();
        end else if (kind == 1) begin
            for (int i = 7; i >= 4; i--) wbit(l[i]);
            bus_start();
            bus_stop();
        end else begin
            for (int i = 7; i >= 1; i--) wbit(l[i]);
            m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
            m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
            bus_stop();
        end
        wt(4);
        chk("R3 register kept", int'(code), int'(exp_code));
    endtask

    task automatic do_foreign(input logic [7:0] v);
        logic a;
        bus_start();
        send_byte(v, a); chk("R10 foreign nack", int'(a), 0);
        bus_stop();
        wt(4);
        chk("R10 register kept", int'(code), int'(exp_code));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] m, x;
        logic [7:0] v;
        void'($urandom(32'd2024));

        // R1: never programmed
        otp_cnt = 3'd0; otp_val = 10'h155;
        wt(3);
        chk("R1 in reset mid-scale", int'(code), 10'h200);
        do_reset();
        chk("R1 mid-scale", int'(code), 10'h200);
        chk("R1 oe idle", int'(sda_oe), 0);
        chk("R1 hs idle", int'(hs), 0);
        // R1: programmed
        otp_cnt = 3'd2; otp_val = 10'h0A5;
        do_reset();
        chk("R1 programmed value", int'(code), 10'h0A5);

        // R2 / R5 basics
        do_write(8'h03, 8'h3C);
        do_read();
        do_write(8'hC1, 8'hF0);
        do_read();
        // R4 reserved high bytes
        do_write(8'h43, 8'h11);
        do_write(8'h22, 8'h99);
        do_read();

        // R6 all counts
        for (int c = 0; c < 6; c++) begin
            otp_cnt = 3'(c);
            do_read();
        end

        // R3 directed: stop after msb, Sr mid lsb, START in eighth lsb bit
        do_abort(0, 8'h02, 8'h77);
        do_abort(1, 8'h01, 8'h00);
        do_abort(2, 8'h03, 8'hFE);

        // R7: master refuses first read byte
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk("R7 addr ack", int'(a), 1);
        recv_byte(m, 1'b0);
        wt(2);
        chk("R7 released after nack", int'(sda_oe), 0);
        recv_byte(x, 1'b0);
        chk("R7 silent after nack", int'(x), 8'hFF);
        bus_stop();

        // R8 master code, kept across Sr, cleared at stop
        bus_start();
        send_byte(8'h0D, a); chk("R8 master code nack", int'(a), 0);
        wt(4);
        chk("R8 hs set", int'(hs), 1);
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R8 addr ack after Sr", int'(a), 1);
        send_byte(8'h01, a); chk("R8 msb ack", int'(a), 1);
        send_byte(8'h5A, a); chk("R8 lsb ack", int'(a), 1);
        exp_code = 10'h15A;
        chk("R8 hs held", int'(hs), 1);
        bus_stop();
        wt(4);
        chk("R8 hs cleared", int'(hs), 0);
        chk("R8 write in fast mode", int'(code), int'(exp_code));

        // R9 general call
        do_gc(8'h07);
        otp_cnt = 3'd0;
        do_gc(8'h06);
        otp_cnt = 3'd4; otp_val = 10'h3C3;
        do_write(8'h00, 8'h01);
        do_gc(8'h06);

        // R10 foreign addresses
        do_foreign({7'h4D, 1'b0});
        do_foreign({7'h10, 1'b1});

        // random mix
        for (int it = 0; it < 36; it++) begin
            case ($urandom_range(0, 6))
                0, 1: do_write(8'($urandom()), 8'($urandom()));
                2: do_read();
                3: do_abort(int'($urandom_range(0, 2)), 8'($urandom()), 8'($urandom()));
                4: do_gc(($urandom_range(0, 1) == 0) ? 8'h06 : 8'($urandom()));
                5: begin
                    do begin
                        v = 8'($urandom());
                    end while (v[7:1] == ADDR || v == 8'h00 || v[7:3] == 5'b00001);
                    do_foreign(v);
                end
                default: begin
                    otp_cnt = 3'($urandom_range(0, 7));
                    otp_val = 10'($urandom());
                    do_read();
                end
            endcase
        end

        chk("R11 oe steady while SCL high", oe_viol, 0);
        finish_run();
    end

endmodule